// File: doc/BRIEF.md
# Two-Slot Ethernet Frame Transmit Buffer

This block sits between a processor's register bus and the byte-wide transmit path of a 10/100 Ethernet MAC. It holds up to two outgoing frames at once, each in its own slot. Software picks a slot and streams the frame into one shared data register as 32-bit words. It then writes the slot's byte length and sets the slot's start bit. The buffer unpacks each word into bytes, lowest byte lane first, and presents them one at a time on a valid/ready byte interface. The bytes carry no preamble and no CRC. Short frames must already be zero-padded by software up to the 60-byte minimum.

Frames leave in the order their start bits were set, so one slot can be refilled while the other is on the wire. Each slot has a completion bit in a shared status register. These bits are write-one-to-clear, and an enable mask combines them into one interrupt line. A slot stays locked against new data, length and start writes from the moment it is started until its final byte is accepted.

Top module: `txbuf_dual_slot`

## Requirements
- R1: After reset every readable register (addresses 0 to 7) reads 0, `tx_valid` is low and `irq` is low.
- R2: Address 0 holds the slot select in bit 0 and reads back. Writing it also rewinds the chosen slot's fill position to word 0. Each write to address 1 (data port) stores the word at the selected slot's fill position and advances that position. Words written beyond the slot capacity are dropped.
- R3: Byte k of a frame is taken from stored word k/4, bits 8*(k mod 4)+7 down to 8*(k mod 4), so the first byte sits in the lowest lane.
- R4: Addresses 2 and 3 hold the byte length of slot 0 and slot 1. A frame emits exactly min(length, capacity) bytes, and `tx_last` is high on the final one. Bytes of the last word beyond the length are never sent.
- R5: Writing 1 to bit 0 of address 4 (slot 0) or address 5 (slot 1) starts that slot. The same bit reads 1 from then until the slot's final byte is accepted, and 0 afterwards.
- R6: When both slots are started, their frames are emitted back to back in the order the start writes arrived.
- R7: A byte is consumed only on a cycle with `tx_valid` and `tx_ready` both high. While stalled, `tx_valid`, `tx_data` and `tx_last` hold.
- R8: Bit s of address 6 is set when slot s completes. Writing 1 to a bit clears it, and a 0 bit leaves it unchanged.
- R9: `irq` is high exactly when some bit of address 6 is set and the same bit of the enable mask at address 7 is set.
- R10: While a slot is busy, data-port writes aimed at it, writes to its length and further start writes to it have no effect.
- R11: A slot started with length 0 completes and sets its status bit without emitting any byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | DATA_W | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq | output | 1 | Masked completion interrupt |
| tx_valid | output | 1 | A frame byte is offered |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Offered byte ends the frame |
| tx_ready | input | 1 | MAC accepts the offered byte |

## Verification
Every length from 0 to two bytes past capacity is swept on both slots, under a ready signal that stalls one cycle in three. A wrong lane order or fill rewind scrambles the bytes. An off-by-one in the last-byte test sends junk from the padding lanes or cuts the frame short. A missing length clamp lets the index run past the slot. Both start orders are tried with the MAC held off, and a design that serves slots by fixed priority sends slot 0 first when slot 1 was started first. Writes to a locked slot, partial write-one-to-clear masks and each enable combination are probed so that a leaking write, a clearing zero bit or an unmasked interrupt shows up in the emitted bytes or in the readback.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
   localparam int unsigned TXB_SLOTS = 2;

   localparam logic [2:0] A_SEL   = 3'd0;
   localparam logic [2:0] A_DATA  = 3'd1;
   localparam logic [2:0] A_LEN0  = 3'd2;
   localparam logic [2:0] A_LEN1  = 3'd3;
   localparam logic [2:0] A_CTL0  = 3'd4;
   localparam logic [2:0] A_CTL1  = 3'd5;
   localparam logic [2:0] A_ISTAT = 3'd6;
   localparam logic [2:0] A_IEN   = 3'd7;
endpackage

// File: rtl/txbuf_slot_store.sv
module txbuf_slot_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORDS  = 16,
   parameter int unsigned LEN_W  = 16,
   parameter int unsigned EFF_W  = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       fill_rewind,
   input  logic                       fill_we,
   input  logic [DATA_W-1:0]          fill_word,
   input  logic                       len_we,
   input  logic [LEN_W-1:0]           len_wdata,
   input  logic                       start_req,
   input  logic                       finish,
   input  logic [$clog2(WORDS)-1:0]   rd_idx,
   output logic [DATA_W-1:0]          rd_word,
   output logic [LEN_W-1:0]           len_q,
   output logic [EFF_W-1:0]           len_eff,
   output logic                       busy_q,
   output logic                       start_ok
);
   localparam int unsigned PTR_W = $clog2(WORDS) + 1;
   localparam int unsigned CAP   = WORDS * (DATA_W / 8);

   logic [DATA_W-1:0] mem [WORDS];
   logic [PTR_W-1:0]  ptr_q;
   logic              room;
   logic              store;

   assign room     = ptr_q < PTR_W'(WORDS);
   assign store    = fill_we && !busy_q && room;
   assign start_ok = start_req && !busy_q;
   assign rd_word  = mem[rd_idx];
   assign len_eff  = (len_q > LEN_W'(CAP)) ? EFF_W'(CAP) : EFF_W'(len_q);

   always_ff @(posedge clk) begin
      if (store) mem[ptr_q[PTR_W-2:0]] <= fill_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         len_q  <= '0;
         busy_q <= 1'b0;
      end else begin
         if (fill_rewind)         ptr_q <= '0;
         else if (store)          ptr_q <= ptr_q + 1'b1;
         if (len_we && !busy_q)   len_q <= len_wdata;
         if (start_ok)            busy_q <= 1'b1;
         else if (finish)         busy_q <= 1'b0;
      end
   end
endmodule

// File: rtl/txbuf_order_q.sv
module txbuf_order_q #(
   parameter int unsigned ENTRIES = 2,
   parameter int unsigned ID_W    = 1,
   parameter int unsigned CNT_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [ID_W-1:0]  push_id,
   input  logic             pop,
   output logic [ID_W-1:0]  head_id,
   output logic             empty,
   output logic [CNT_W-1:0] count
);
   localparam int unsigned IW = $clog2(ENTRIES);

   logic [ID_W-1:0]  ids_q [ENTRIES];
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] wr_pos;

   assign wr_pos  = pop ? cnt_q - 1'b1 : cnt_q;
   assign head_id = ids_q[0];
   assign empty   = (cnt_q == '0);
   assign count   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < ENTRIES; i++) ids_q[i] <= '0;
      end else begin
         if (pop) begin
            for (int i = 0; i < ENTRIES - 1; i++) ids_q[i] <= ids_q[i+1];
         end
         if (push) ids_q[wr_pos[IW-1:0]] <= push_id;
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
   end
endmodule

// File: rtl/txbuf_byte_tx.sv
module txbuf_byte_tx #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SLOTS  = 2,
   parameter int unsigned ID_W   = 1,
   parameter int unsigned WORDS  = 16,
   parameter int unsigned EFF_W  = 7
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         q_empty,
   input  logic [ID_W-1:0]              q_head,
   output logic                         q_pop,
   input  logic [SLOTS-1:0][EFF_W-1:0]  len_eff,
   output logic [ID_W-1:0]              rd_slot,
   output logic [$clog2(WORDS)-1:0]     rd_idx,
   input  logic [DATA_W-1:0]            rd_word,
   output logic                         tx_valid,
   output logic [7:0]                   tx_data,
   output logic                         tx_last,
   input  logic                         tx_ready,
   output logic [SLOTS-1:0]             finish
);
   localparam int unsigned LANE_W = $clog2(DATA_W / 8);
   localparam int unsigned WIDX_W = $clog2(WORDS);

   logic             active_q;
   logic [ID_W-1:0]  cur_q;
   logic [EFF_W-1:0] bidx_q;
   logic [EFF_W-1:0] head_len;
   logic [EFF_W-1:0] cur_len;
   logic [LANE_W-1:0] lane;

   assign head_len = len_eff[q_head];
   assign cur_len  = len_eff[cur_q];
   assign lane     = bidx_q[LANE_W-1:0];
   assign q_pop    = !active_q && !q_empty;
   assign rd_slot  = cur_q;
   assign rd_idx   = bidx_q[LANE_W +: WIDX_W];
   assign tx_valid = active_q;
   assign tx_last  = active_q && (bidx_q == cur_len - 1'b1);
   assign tx_data  = rd_word[8*lane +: 8];

   always_comb begin
      finish = '0;
      if (active_q && tx_ready && tx_last) finish[cur_q] = 1'b1;
      if (q_pop && head_len == '0)         finish[q_head] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cur_q    <= '0;
         bidx_q   <= '0;
      end else if (q_pop) begin
         cur_q    <= q_head;
         bidx_q   <= '0;
         active_q <= (head_len != '0);
      end else if (active_q && tx_ready) begin
         if (tx_last) active_q <= 1'b0;
         else         bidx_q   <= bidx_q + 1'b1;
      end
   end
endmodule

// File: rtl/txbuf_dual_slot.sv
module txbuf_dual_slot
   import txbuf_pkg::*;
#(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned WORDS_PER_SLOT = 16,
   parameter int unsigned LEN_W          = 16,
   parameter bit          IRQ_REG        = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_waddr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [2:0]        reg_raddr,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   input  logic              tx_ready
);
   localparam int unsigned SLOTS  = TXB_SLOTS;
   localparam int unsigned ID_W   = $clog2(SLOTS);
   localparam int unsigned CNT_W  = $clog2(SLOTS + 1);
   localparam int unsigned CAP    = WORDS_PER_SLOT * (DATA_W / 8);
   localparam int unsigned EFF_W  = $clog2(CAP + 1);
   localparam int unsigned WIDX_W = $clog2(WORDS_PER_SLOT);

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if (WORDS_PER_SLOT < 2) begin : g_bad_words
      $error("WORDS_PER_SLOT must be at least 2");
   end
   if (LEN_W < EFF_W || LEN_W > DATA_W) begin : g_bad_len_w
      $error("LEN_W must cover the slot capacity and fit a data word");
   end

   logic [ID_W-1:0]               sel_q;
   logic [SLOTS-1:0]              istat_q;
   logic [SLOTS-1:0]              ien_q;
   logic [SLOTS-1:0]              fill_we, rewind, len_we, start_req, start_ok;
   logic [SLOTS-1:0]              slot_busy, finish;
   logic [DATA_W-1:0]             slot_word [SLOTS];
   logic [SLOTS-1:0][LEN_W-1:0]   len_q;
   logic [SLOTS-1:0][EFF_W-1:0]   len_eff;
   logic [ID_W-1:0]               rd_slot, q_head, push_id;
   logic [WIDX_W-1:0]             rd_idx;
   logic                          q_pop, q_empty, push;
   logic [CNT_W-1:0]              q_count;
   logic [SLOTS-1:0]              w1c;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign fill_we[s]   = reg_we && reg_waddr == A_DATA && sel_q == ID_W'(s);
      assign rewind[s]    = reg_we && reg_waddr == A_SEL && reg_wdata[ID_W-1:0] == ID_W'(s);
      assign len_we[s]    = reg_we && reg_waddr == A_LEN0 + 3'(s);
      assign start_req[s] = reg_we && reg_waddr == A_CTL0 + 3'(s) && reg_wdata[0];

      txbuf_slot_store #(
         .DATA_W(DATA_W), .WORDS(WORDS_PER_SLOT), .LEN_W(LEN_W), .EFF_W(EFF_W)
      ) u_store (
         .clk        (clk),
         .rst_n      (rst_n),
         .fill_rewind(rewind[s]),
         .fill_we    (fill_we[s]),
         .fill_word  (reg_wdata),
         .len_we     (len_we[s]),
         .len_wdata  (reg_wdata[LEN_W-1:0]),
         .start_req  (start_req[s]),
         .finish     (finish[s]),
         .rd_idx     (rd_idx),
         .rd_word    (slot_word[s]),
         .len_q      (len_q[s]),
         .len_eff    (len_eff[s]),
         .busy_q     (slot_busy[s]),
         .start_ok   (start_ok[s])
      );
   end

   assign push = |start_ok;
   always_comb begin
      push_id = '0;
      for (int s = 0; s < SLOTS; s++) if (start_ok[s]) push_id = ID_W'(s);
   end

   txbuf_order_q #(.ENTRIES(SLOTS), .ID_W(ID_W), .CNT_W(CNT_W)) u_order (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (push),
      .push_id(push_id),
      .pop    (q_pop),
      .head_id(q_head),
      .empty  (q_empty),
      .count  (q_count)
   );

   txbuf_byte_tx #(
      .DATA_W(DATA_W), .SLOTS(SLOTS), .ID_W(ID_W), .WORDS(WORDS_PER_SLOT), .EFF_W(EFF_W)
   ) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .q_empty (q_empty),
      .q_head  (q_head),
      .q_pop   (q_pop),
      .len_eff (len_eff),
      .rd_slot (rd_slot),
      .rd_idx  (rd_idx),
      .rd_word (slot_word[rd_slot]),
      .tx_valid(tx_valid),
      .tx_data (tx_data),
      .tx_last (tx_last),
      .tx_ready(tx_ready),
      .finish  (finish)
   );

   assign w1c = (reg_we && reg_waddr == A_ISTAT) ? reg_wdata[SLOTS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         istat_q <= '0;
         ien_q   <= '0;
      end else begin
         if (reg_we && reg_waddr == A_SEL) sel_q <= reg_wdata[ID_W-1:0];
         if (reg_we && reg_waddr == A_IEN) ien_q <= reg_wdata[SLOTS-1:0];
         istat_q <= (istat_q & ~w1c) | finish;
      end
   end

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(istat_q & ien_q);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(istat_q & ien_q);
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_raddr)
         A_SEL:   reg_rdata[ID_W-1:0]  = sel_q;
         A_LEN0:  reg_rdata[LEN_W-1:0] = len_q[0];
         A_LEN1:  reg_rdata[LEN_W-1:0] = len_q[1];
         A_CTL0:  reg_rdata[0]         = slot_busy[0];
         A_CTL1:  reg_rdata[0]         = slot_busy[1];
         A_ISTAT: reg_rdata[SLOTS-1:0] = istat_q;
         A_IEN:   reg_rdata[SLOTS-1:0] = ien_q;
         default: reg_rdata            = '0;
      endcase
   end
endmodule

// File: rtl/txbuf_dual_slot_chk.sv
module txbuf_dual_slot_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_data,
   input logic       tx_last,
   input logic [1:0] busy,
   input logic [1:0] istat,
   input logic [1:0] q_count
);
   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

   // R4
   last_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   // R5
   valid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> busy != 2'b00);

   // R8
   done0_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[0]) |-> istat[0]);

   // R8
   done1_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[1]) |-> istat[1]);

   // R8
   flag0_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(istat[0]) |-> $past(busy[0]));

   // R8
   flag1_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(istat[1]) |-> $past(busy[1]));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= 2'd2);
endmodule

bind txbuf_dual_slot txbuf_dual_slot_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tx_valid(tx_valid),
   .tx_ready(tx_ready),
   .tx_data (tx_data),
   .tx_last (tx_last),
   .busy    (slot_busy),
   .istat   (istat_q),
   .q_count (q_count)
);

// File: tb/txbuf_dual_slot_tb.sv
`timescale 1ns/1ps
module txbuf_dual_slot_tb;
   localparam int WORDS = 16;
   localparam int CAP   = WORDS * 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_waddr = '0;
   logic [31:0] reg_wdata = '0;
   logic [2:0]  reg_raddr = '0;
   logic [31:0] reg_rdata;
   logic        irq, tx_valid, tx_last;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b0;

   txbuf_dual_slot u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .tx_ready(tx_ready)
   );

   always #5 clk = ~clk;

   int  checks = 0;
   int  fails  = 0;
   bit  done_flag = 0;

   task automatic check_eq(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // ready pattern, changed just after each rising edge
   int   cyc = 0;
   logic hold = 1'b0;
   always @(posedge clk) begin
      cyc++;
      #1 tx_ready = !hold && (cyc % 3 != 2);
   end

   // byte monitor, sampled on the falling edge
   logic [7:0] rx_buf [0:255];
   int   rx_cnt = 0;
   int   rx_last_idx = -1;
   int   stall_errs = 0;
   int   stall_seen = 0;
   logic prev_stall = 1'b0;
   logic [7:0] prev_data = '0;
   logic prev_last = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall && (!tx_valid || tx_data !== prev_data || tx_last !== prev_last))
            stall_errs++;
         prev_stall = tx_valid && !tx_ready;
         if (prev_stall) stall_seen++;
         prev_data = tx_data;
         prev_last = tx_last;
         if (tx_valid && tx_ready) begin
            if (rx_cnt < 256) rx_buf[rx_cnt] = tx_data;
            if (tx_last) rx_last_idx = rx_cnt;
            rx_cnt++;
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_raddr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [7:0] pat(input int slot, input int len, input int i);
      return 8'((slot * 128) ^ ((i * 5 + len) & 127));
   endfunction

   task automatic load_frame(input int slot, input int len);
      int nw;
      logic [31:0] w;
      wr(3'd0, 32'(slot));
      nw = (len + 3) / 4;
      if (nw > WORDS) nw = WORDS + 1;
      for (int k = 0; k < nw; k++) begin
         for (int j = 0; j < 4; j++)
            w[8*j +: 8] = (4*k + j < len) ? pat(slot, len, 4*k + j) : 8'hEE;
         wr(3'd1, w);
      end
      wr(3'(2 + slot), 32'(len));
   endtask

   task automatic wait_done(input int slot);
      logic [31:0] v;
      bit seen = 0;
      for (int t = 0; t < 3000 && !seen; t++) begin
         rd(3'd6, v);
         seen = v[slot];
      end
      check_eq("R8", "completion flag seen", seen, 1);
   endtask

   task automatic clear_rx();
      rx_cnt = 0;
      rx_last_idx = -1;
   endtask

   task automatic run_frame(input int slot, input int len);
      int exp, bad;
      logic [31:0] v;
      clear_rx();
      load_frame(slot, len);
      wr(3'(4 + slot), 32'd1);
      wait_done(slot);
      exp = (len > CAP) ? CAP : len;
      if (len == 0) check_eq("R11", "bytes from empty frame", rx_cnt, 0);
      else          check_eq("R4", "byte count", rx_cnt, exp);
      bad = 0;
      for (int i = 0; i < exp && i < rx_cnt; i++)
         if (rx_buf[i] !== pat(slot, len, i)) bad++;
      check_eq("R3", "mismatched bytes", bad, 0);
      if (exp > 0) check_eq("R4", "last flag position", rx_last_idx, exp - 1);
      rd(3'(4 + slot), v);
      check_eq("R5", "start bit after send", v[0], 0);
      wr(3'd6, 32'(1 << slot));
      rd(3'd6, v);
      check_eq("R8", "flag after clear", v[slot], 0);
   endtask

   initial begin
      #(200000 * 10);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         check_eq("R1", $sformatf("reg %0d after reset", a), v, 0);
      end
      check_eq("R1", "tx_valid after reset", tx_valid, 0);
      check_eq("R1", "irq after reset", irq, 0);

      // R2 select readback
      wr(3'd0, 32'd1);
      rd(3'd0, v);
      check_eq("R2", "slot select readback", v, 1);

      // R3 R4 R11 sweep of lengths on both slots
      for (int len = 0; len <= CAP + 2; len++)
         for (int s = 0; s < 2; s++)
            run_frame(s, len);

      // R6 slot 1 started first
      hold = 1'b1;
      clear_rx();
      load_frame(1, 8);
      load_frame(0, 12);
      wr(3'd5, 32'd1);
      wr(3'd4, 32'd1);
      rd(3'd4, v); check_eq("R5", "slot 0 busy readback", v[0], 1);
      rd(3'd5, v); check_eq("R5", "slot 1 busy readback", v[0], 1);
      hold = 1'b0;
      wait_done(0);
      check_eq("R6", "two frame byte count", rx_cnt, 20);
      bad = 0;
      for (int i = 0; i < 8; i++)  if (rx_buf[i] !== pat(1, 8, i)) bad++;
      for (int i = 0; i < 12; i++) if (rx_buf[8+i] !== pat(0, 12, i)) bad++;
      check_eq("R6", "order slot1 then slot0", bad, 0);
      wr(3'd6, 32'd3);

      // R6 slot 0 started first
      hold = 1'b1;
      clear_rx();
      load_frame(0, 6);
      load_frame(1, 10);
      wr(3'd4, 32'd1);
      wr(3'd5, 32'd1);
      hold = 1'b0;
      wait_done(1);
      check_eq("R6", "two frame byte count", rx_cnt, 16);
      bad = 0;
      for (int i = 0; i < 6; i++)  if (rx_buf[i] !== pat(0, 6, i)) bad++;
      for (int i = 0; i < 10; i++) if (rx_buf[6+i] !== pat(1, 10, i)) bad++;
      check_eq("R6", "order slot0 then slot1", bad, 0);

      // R8 R9 both flags set now
      rd(3'd6, v); check_eq("R8", "both flags", v, 3);
      wr(3'd7, 32'd0); #1 check_eq("R9", "irq masked off", irq, 0);
      wr(3'd7, 32'd1); #1 check_eq("R9", "irq enable bit0", irq, 1);
      wr(3'd6, 32'd2);
      rd(3'd6, v); check_eq("R8", "clear bit1 only", v, 1);
      wr(3'd6, 32'd0);
      rd(3'd6, v); check_eq("R8", "zero write keeps flags", v, 1);
      wr(3'd7, 32'd2); #1 check_eq("R9", "irq enable bit1 only", irq, 0);
      wr(3'd7, 32'd3); #1 check_eq("R9", "irq both enabled", irq, 1);
      wr(3'd6, 32'd1);
      #1 check_eq("R9", "irq after clear", irq, 0);
      wr(3'd7, 32'd0);

      // R10 writes to a busy slot
      hold = 1'b1;
      clear_rx();
      load_frame(0, 8);
      wr(3'd4, 32'd1);
      wr(3'd2, 32'd3);
      rd(3'd2, v); check_eq("R10", "length locked while busy", v, 8);
      wr(3'd0, 32'd0);
      wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd4, 32'd1);
      hold = 1'b0;
      wait_done(0);
      wr(3'd6, 32'd1);
      repeat (100) @(negedge clk);
      check_eq("R10", "byte count with locked slot", rx_cnt, 8);
      bad = 0;
      for (int i = 0; i < 8; i++) if (rx_buf[i] !== pat(0, 8, i)) bad++;
      check_eq("R10", "data locked while busy", bad, 0);
      rd(3'd6, v); check_eq("R10", "no second completion", v, 0);

      // R7 handshake
      check_eq("R7", "stall hold errors", stall_errs, 0);
      check_eq("R7", "stalls exercised", stall_seen > 0, 1);
      finish_run();
   end
endmodule